// File: doc/BRIEF.md
# Constant-Delay Time-Slot Interchanger

This block moves byte-wide channels from one position in a serial TDM frame to another. One stream comes in and one stream goes out, both as parallel bytes with one time slot per `slot_en` cycle. Each incoming byte is stored in a frame buffer at its channel position. For each outgoing slot, a per-output connection entry names the source channel and the delay discipline. The output byte is fetched from one of three frame buffers that are used in rotation.

Two delay disciplines can be set per output channel. With minimum delay, the byte leaves in the same frame if its source channel has already arrived. Otherwise it leaves one frame later. With constant delay, every connection takes the same route in whole frames. The byte that arrives in slot n of frame F always leaves in slot m of frame F+2. This gives 2N+m-n-1 whole slots between the two, whatever n and m are. The frame holds 32, 64 or 128 channels, selected by a rate code. A frame pulse realigns the slot count, and without a pulse the count wraps on its own.

Top module: `tdm_slot_switch`

## Requirements
- R1: While `rst_n` is low, `tx_valid`, `tx_chan` and `tx_byte` are all zero.
- R2: `rate_sel` sets the frame length: 2'b00 gives 32 channels, 2'b01 gives 64, and 2'b10 and 2'b11 give 128. Without a frame pulse, the channel after the last one is channel 0 of a new frame.
- R3: A connection entry with `cm_const`=1 and source n, on output channel m, sends in slot m of frame F+2 the byte that entered in slot n of frame F.
- R4: A minimum-delay entry (`cm_const`=0) whose source n is lower than the output channel m sends the byte that entered in slot n of the same frame.
- R5: A minimum-delay entry whose source n is equal to or higher than m sends the byte that entered in slot n of the previous frame.
- R6: `frame_pulse` high together with `slot_en` makes that slot channel 0 and starts a new frame, also in the middle of a frame.
- R7: `tx_valid` is high in exactly the cycle after a cycle with `slot_en` high. `tx_chan` then gives the output channel of that slot. A cycle without `slot_en` advances neither the channel nor the frame.
- R8: A connection entry is written when `cm_we` is high, at index `cm_addr`, with fields {`cm_const`, `cm_src`}. Any slot from the next cycle on uses the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_sel | input | 2 | Frame length code |
| slot_en | input | 1 | A time slot occurs in this cycle |
| frame_pulse | input | 1 | This slot is channel 0 of a new frame |
| rx_byte | input | 8 | Incoming byte for the current slot |
| cm_we | input | 1 | Connection entry write strobe |
| cm_addr | input | 7 | Output channel whose entry is written |
| cm_const | input | 1 | 1 = constant delay, 0 = minimum delay |
| cm_src | input | 7 | Source input channel |
| tx_valid | output | 1 | Output byte valid (one cycle after the slot) |
| tx_chan | output | 7 | Output channel of the presented byte |
| tx_byte | output | 8 | Switched output byte |

## Verification
Two things can happen in the same cycle. The incoming byte is written into the current frame buffer, and an output slot reads a frame buffer at the same channel position. This happens whenever a minimum-delay entry names its own channel, and it must return the previous frame and not the byte now arriving. The bench programs such self-connections, and both delay modes, on neighbouring channels. It judges every output byte against a value computed from the frame index and the channel number. The frame pulse meeting the natural wrap, and a pulse in the middle of a frame, are also run. After each, the channel sequence and the resumed byte stream are checked.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  localparam int CH_BITS   = 7;
  localparam int BYTE_BITS = 8;
  localparam int BUF_COUNT = 3;
  localparam int BUF_BITS  = 2;
  localparam int CH_MAX    = 1 << CH_BITS;

  typedef enum logic [1:0] {
    RATE_QUARTER = 2'b00,
    RATE_HALF    = 2'b01,
    RATE_FULL    = 2'b10,
    RATE_ALT     = 2'b11
  } rate_e;

  typedef struct packed {
    logic               const_dly;
    logic [CH_BITS-1:0] src;
  } conn_t;

  // Channel count of one frame for a rate code.
  function automatic logic [CH_BITS:0] frame_len(input logic [1:0] rate);
    case (rate_e'(rate))
      RATE_QUARTER: frame_len = (CH_BITS+1)'(CH_MAX >> 2);
      RATE_HALF:    frame_len = (CH_BITS+1)'(CH_MAX >> 1);
      default:      frame_len = (CH_BITS+1)'(CH_MAX);
    endcase
  endfunction

  // Rotation step forward and back through the three buffers.
  function automatic logic [BUF_BITS-1:0] buf_fwd(input logic [BUF_BITS-1:0] b);
    buf_fwd = (b == BUF_BITS'(BUF_COUNT - 1)) ? '0 : b + 1'b1;
  endfunction

  function automatic logic [BUF_BITS-1:0] buf_back(input logic [BUF_BITS-1:0] b);
    buf_back = (b == '0) ? BUF_BITS'(BUF_COUNT - 1) : b - 1'b1;
  endfunction

  // Buffer holding the byte an output slot must send.
  //   constant delay : oldest buffer (two frames back)
  //   minimum delay  : current buffer if the source is already written, else previous
  function automatic logic [BUF_BITS-1:0] pick_buf(
      input logic                const_dly,
      input logic [CH_BITS-1:0]  src,
      input logic [CH_BITS-1:0]  dst,
      input logic [BUF_BITS-1:0] wbuf);
    if (const_dly)      pick_buf = buf_fwd(wbuf);
    else if (src < dst) pick_buf = wbuf;
    else                pick_buf = buf_back(wbuf);
  endfunction

endpackage

// File: rtl/tsi_slot_timer.sv
module tsi_slot_timer
  import tsi_pkg::*;
#(
  parameter int CHW = CH_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slot_en,
  input  logic                frame_pulse,
  input  logic [1:0]          rate_sel,
  output logic [CHW-1:0]      ch_now,
  output logic [BUF_BITS-1:0] wbuf_now,
  output logic                frame_start
);

  localparam logic [CHW:0] ONE = 1;

  logic [CHW:0]          nch;
  logic [CHW-1:0]        cnt_q;
  logic                  in_frame_q;
  logic [BUF_BITS-1:0]   wbuf_q;
  logic                  last_slot;

  assign nch         = frame_len(rate_sel);
  assign frame_start = slot_en & (frame_pulse | (in_frame_q & (cnt_q == '0)));
  assign ch_now      = frame_pulse ? '0 : cnt_q;
  assign wbuf_now    = frame_start ? buf_fwd(wbuf_q) : wbuf_q;
  assign last_slot   = ({1'b0, ch_now} >= (nch - ONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      wbuf_q     <= '0;
    end else if (slot_en) begin
      cnt_q      <= last_slot ? '0 : ch_now + 1'b1;
      in_frame_q <= 1'b1;
      wbuf_q     <= wbuf_now;
    end
  end

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
  import tsi_pkg::*;
#(
  parameter int CHW = CH_BITS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [CHW-1:0] waddr,
  input  conn_t          wdata,
  input  logic [CHW-1:0] raddr,
  output conn_t          rdata
);

  localparam int DEPTH = 1 << CHW;

  conn_t entry_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) entry_q[i] <= '0;
    end else if (we) begin
      entry_q[waddr] <= wdata;
    end
  end

  assign rdata = entry_q[raddr];

endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
  import tsi_pkg::*;
#(
  parameter int CHW = CH_BITS,
  parameter int DW  = BYTE_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [BUF_BITS-1:0] wbuf,
  input  logic [CHW-1:0]      wch,
  input  logic [DW-1:0]       wdata,
  input  logic                re,
  input  logic [BUF_BITS-1:0] rbuf,
  input  logic [CHW-1:0]      rch,
  output logic [DW-1:0]       rdata
);

  localparam int AW    = BUF_BITS + CHW;
  localparam int DEPTH = BUF_COUNT << CHW;

  logic [DW-1:0] cell_q [DEPTH];
  logic [AW-1:0] widx;
  logic [AW-1:0] ridx;

  assign widx = {wbuf, wch};
  assign ridx = {rbuf, rch};

  always_ff @(posedge clk) begin
    if (we) cell_q[widx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= cell_q[ridx];
  end

endmodule

// File: rtl/tdm_slot_switch.sv
module tdm_slot_switch
  import tsi_pkg::*;
#(
  parameter int CHW = CH_BITS,
  parameter int DW  = BYTE_BITS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     rate_sel,
  input  logic           slot_en,
  input  logic           frame_pulse,
  input  logic [DW-1:0]  rx_byte,
  input  logic           cm_we,
  input  logic [CHW-1:0] cm_addr,
  input  logic           cm_const,
  input  logic [CHW-1:0] cm_src,
  output logic           tx_valid,
  output logic [CHW-1:0] tx_chan,
  output logic [DW-1:0]  tx_byte
);

  // Named internal events, observed by the bound checker
  logic [CHW-1:0]      cur_ch;
  logic [BUF_BITS-1:0] wr_buf;
  logic [BUF_BITS-1:0] rd_buf;
  logic                frame_start;
  logic                sel_const;
  logic [CHW-1:0]      sel_src;

  conn_t cm_wentry;
  conn_t cm_rentry;

  tsi_slot_timer #(.CHW(CHW)) timer_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_en     (slot_en),
    .frame_pulse (frame_pulse),
    .rate_sel    (rate_sel),
    .ch_now      (cur_ch),
    .wbuf_now    (wr_buf),
    .frame_start (frame_start)
  );

  assign cm_wentry = '{const_dly: cm_const, src: cm_src};

  tsi_conn_mem #(.CHW(CHW)) conn_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cm_we),
    .waddr (cm_addr),
    .wdata (cm_wentry),
    .raddr (cur_ch),
    .rdata (cm_rentry)
  );

  assign sel_const = cm_rentry.const_dly;
  assign sel_src   = cm_rentry.src;
  assign rd_buf    = pick_buf(sel_const, sel_src, cur_ch, wr_buf);

  tsi_data_mem #(.CHW(CHW), .DW(DW)) data_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (slot_en),
    .wbuf  (wr_buf),
    .wch   (cur_ch),
    .wdata (rx_byte),
    .re    (slot_en),
    .rbuf  (rd_buf),
    .rch   (sel_src),
    .rdata (tx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_chan  <= '0;
    end else begin
      tx_valid <= slot_en;
      if (slot_en) tx_chan <= cur_ch;
    end
  end

endmodule

// File: rtl/tdm_slot_switch_chk.sv
module tdm_slot_switch_chk
  import tsi_pkg::*;
#(
  parameter int CHW = CH_BITS
) (
  input logic                clk,
  input logic                rst_n,
  input logic                slot_en,
  input logic                frame_pulse,
  input logic                tx_valid,
  input logic [CHW-1:0]      tx_chan,
  input logic [CHW-1:0]      cur_ch,
  input logic [BUF_BITS-1:0] wr_buf,
  input logic [BUF_BITS-1:0] rd_buf,
  input logic                sel_const,
  input logic [CHW-1:0]      sel_src
);

  assert_valid_follows_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slot_en |=> tx_valid);

  assert_idle_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en |=> !tx_valid);

  assert_pulse_chan_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && frame_pulse) |=> (tx_chan == '0));

  assert_const_old_buf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && sel_const) |-> (rd_buf != wr_buf));

  assert_var_early_same_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && !sel_const && (sel_src < cur_ch)) |-> (rd_buf == wr_buf));

  assert_var_late_prev_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && !sel_const && (sel_src >= cur_ch)) |-> (rd_buf != wr_buf));

  assert_buf_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_en |-> ((rd_buf < BUF_BITS'(BUF_COUNT)) && (wr_buf < BUF_BITS'(BUF_COUNT))));

endmodule

bind tdm_slot_switch tdm_slot_switch_chk #(.CHW(CHW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .slot_en     (slot_en),
  .frame_pulse (frame_pulse),
  .tx_valid    (tx_valid),
  .tx_chan     (tx_chan),
  .cur_ch      (cur_ch),
  .wr_buf      (wr_buf),
  .rd_buf      (rd_buf),
  .sel_const   (sel_const),
  .sel_src     (sel_src)
);

// File: tb/tdm_slot_switch_tb_top.sv
module tdm_slot_switch_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] rate_sel;
  logic       slot_en;
  logic       frame_pulse;
  logic [7:0] rx_byte;
  logic       cm_we;
  logic [6:0] cm_addr;
  logic       cm_const;
  logic [6:0] cm_src;
  logic       tx_valid;
  logic [6:0] tx_chan;
  logic [7:0] tx_byte;

  always #4 clk = ~clk;

  tdm_slot_switch dut_i (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .slot_en(slot_en),
    .frame_pulse(frame_pulse), .rx_byte(rx_byte), .cm_we(cm_we),
    .cm_addr(cm_addr), .cm_const(cm_const), .cm_src(cm_src),
    .tx_valid(tx_valid), .tx_chan(tx_chan), .tx_byte(tx_byte)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int cm_src_m [128];
  bit cm_c_m   [128];

  int cur_f = -1, nxt_ch = 0, nlen = 32, clean = 0, wcount = 0, sc = 0;
  bit started = 0;
  bit pend = 0, pidle = 0, r8_mark = 0;
  int p_m, p_exp;
  string p_ctag, p_btag;

  function automatic int dat(int f, int ch);
    return (f * 37 + ch * 5 + 11) & 255;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle_check();
    if (pend) begin
      check(tx_valid == 1'b1, "R7 valid", int'(tx_valid), 1);
      check(int'(tx_chan) == p_m, p_ctag, int'(tx_chan), p_m);
      if (p_exp >= 0) check(int'(tx_byte) == p_exp, p_btag, int'(tx_byte), p_exp);
    end else if (pidle) begin
      check(tx_valid == 1'b0, "R7 idle", int'(tx_valid), 0);
    end
    pend = 0;
    pidle = 0;
  endtask

  task automatic idle();
    @(negedge clk);
    settle_check();
    slot_en = 0; frame_pulse = 0; cm_we = 0;
    pidle = 1;
  endtask

  task automatic cm_write(int m, bit c, int src);
    @(negedge clk);
    settle_check();
    slot_en = 0; frame_pulse = 0;
    cm_we = 1; cm_addr = 7'(m); cm_const = c; cm_src = 7'(src);
    cm_src_m[m] = src; cm_c_m[m] = c;
    pidle = 1;
  endtask

  task automatic slot(bit pulse);
    int m, n;
    bit st;
    @(negedge clk);
    settle_check();
    st = pulse || (started && nxt_ch == 0);
    if (st) begin
      clean = (wcount == nlen) ? clean + 1 : 0;
      cur_f++;
      wcount = 0;
      m = 0;
    end else m = nxt_ch;
    started = 1;
    wcount++;
    nxt_ch = (m >= nlen - 1) ? 0 : m + 1;
    cm_we = 0; slot_en = 1; frame_pulse = pulse; rx_byte = 8'(dat(cur_f, m));
    n = cm_src_m[m];
    p_m = m;
    p_ctag = pulse ? "R6 chan" : (m == 0 ? "R2 chan" : "R7 chan");
    if (clean >= 2) begin
      if (cm_c_m[m]) begin
        p_exp = dat(cur_f - 2, n); p_btag = "R3 byte";
      end else if (n < m) begin
        p_exp = dat(cur_f, n); p_btag = "R4 byte";
      end else begin
        p_exp = dat(cur_f - 1, n); p_btag = "R5 byte";
      end
      if (r8_mark) p_btag = "R8 byte";
    end else p_exp = -1;
    r8_mark = 0;
    pend = 1;
    sc++;
    if (sc % 13 == 12) idle();
  endtask

  task automatic run_frame(bit pulse_first, int len);
    for (int ch = 0; ch < len; ch++) slot(pulse_first && ch == 0);
  endtask

  task automatic set_rate(logic [1:0] r, int len);
    @(negedge clk);
    settle_check();
    slot_en = 0; frame_pulse = 0; cm_we = 0;
    rate_sel = r; nlen = len; wcount = 0;
    pidle = 1;
  endtask

  task automatic prog(int len);
    for (int m = 0; m < 128; m++) begin
      if (m == 5)      cm_write(m, 0, 5);
      else if (m == 9) cm_write(m, 1, 9);
      else             cm_write(m, bit'(m % 2), (m * 7 + 3) % len);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rate_sel = 2'b00; slot_en = 0; frame_pulse = 0; rx_byte = 0;
    cm_we = 0; cm_addr = 0; cm_const = 0; cm_src = 0;
    for (int i = 0; i < 128; i++) begin cm_src_m[i] = 0; cm_c_m[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tx_valid == 1'b0, "R1 valid", int'(tx_valid), 0);
    check(tx_chan == 7'd0, "R1 chan", int'(tx_chan), 0);
    check(tx_byte == 8'd0, "R1 byte", int'(tx_byte), 0);
    rst_n = 1;

    // 32-channel frames, pulsed, then free-running wrap (R2)
    set_rate(2'b00, 32);
    prog(32);
    for (int f = 0; f < 5; f++) run_frame(1, 32);
    run_frame(0, 32);
    run_frame(0, 32);
    // connection rewrite just before its slot (R8)
    for (int ch = 0; ch < 32; ch++) begin
      if (ch == 3) begin cm_write(3, 1, 20); r8_mark = 1; end
      slot(0);
    end
    // truncated frame, realigned by a pulse mid-frame (R6)
    for (int ch = 0; ch < 10; ch++) slot(0);
    for (int f = 0; f < 3; f++) run_frame(1, 32);

    // 64-channel frames
    set_rate(2'b01, 64);
    prog(64);
    for (int f = 0; f < 4; f++) run_frame(1, 64);

    // 128-channel frames, both codes
    set_rate(2'b10, 128);
    prog(128);
    for (int f = 0; f < 4; f++) run_frame(1, 128);
    set_rate(2'b11, 128);
    run_frame(1, 128);
    run_frame(0, 128);
    run_frame(0, 128);

    idle();
    idle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule